// File: doc/BRIEF.md
# Transmit Command Sequencer with Descriptor Prefetch

This block carries out one transmit command. Software places a command block in memory and pulses `start` with its address. The sequencer reads three words from the block: a header, a descriptor-array pointer, and a word that holds the in-block payload size and the descriptor count. It then moves the frame data into the transmit path by issuing requests to a DMA engine. When the pointer is all ones, the only payload is the one stored inside the command block. Otherwise the sequencer also walks an array of buffer descriptors. Each descriptor gives a buffer address and a byte count.

To keep the DMA engine busy, the sequencer reads descriptor N+1 from memory while the DMA engine is still moving buffer N. After the last buffer's DMA completes, it writes a single end-of-command marker into the transmit FIFO. It then writes the header back with the completion bit set. The completion is posted as soon as the whole frame has entered the FIFO. It does not wait for the frame to leave on the line.

Top module: `tx_cmd_seq`

## Requirements
- R1: When the pointer word (offset +4) is all ones, no descriptor word is ever read, and the only DMA issued is the in-block one (if the size is nonzero).
- R2: Command block layout: header at +0, pointer at +4, size at +8 bits [15:0], descriptor count at +8 bits [23:16]. A nonzero size issues a first DMA at block address +12 with the size as its length.
- R3: A zero size issues no in-block DMA, and the sequence moves straight on to the descriptor buffers.
- R4: Descriptor i sits at pointer + 8*i. Its word 0 is the buffer address and bits [15:0] of its word 1 are the length. Buffer DMAs are issued in index order, and only one is outstanding at a time.
- R5: When the next descriptor is already fetched, its DMA starts exactly two cycles after the `dma_done` cycle of the previous transfer.
- R6: In flexible mode, exactly as many descriptors are fetched as the count field gives (two reads each), and no more.
- R7: `eoc_wr` pulses exactly once per command, for one cycle, and only after the last DMA has completed.
- R8: After the marker, the header word is written back to block offset +0 with bit 15 set and all other bits unchanged. `done` then pulses once.
- R9: If a DMA completes before the next descriptor has arrived, the sequencer waits for that descriptor before it issues any DMA.
- R10: In flexible mode with a count of zero and a size of zero, the marker and the write-back happen with no DMA at all.
- R11: A memory request holds its address and direction steady from its first cycle until `mem_ack`.
- R12: After reset, `busy`, `done`, `mem_req`, `dma_start` and `eoc_wr` are all low. `busy` stays high from `start` until `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse that begins a command (accepted when idle) |
| cb_addr | input | AW | Byte address of the command block |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle pulse after the completion write-back |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address of the access |
| mem_wdata | output | DW | Write data |
| mem_ack | input | 1 | Access complete; read data valid in this cycle |
| mem_rdata | input | DW | Read data |
| dma_start | output | 1 | One-cycle pulse launching a transfer |
| dma_addr | output | AW | Transfer source address |
| dma_len | output | LW | Transfer byte count |
| dma_done | input | 1 | Pulse marking that the outstanding transfer has finished |
| eoc_wr | output | 1 | One-cycle write of the end-of-command marker into the transmit FIFO |

## Verification
Several corner cases are targeted directly. A zero size in flexible mode catches a design that issues an empty in-block transfer, or one that never moves on to the descriptors. An all-ones pointer catches a design that reads descriptors anyway, and the resulting stray reads show up in the count of fetches outside the command block. A long DMA latency with fast memory checks the two-cycle hand-off between buffers; a design that only starts fetching after `dma_done` would show larger gaps. Slow memory with an instant DMA forces a stall, so a design that launched before its descriptor arrived would send a stale address or length. A zero count checks that the marker and the write-back still happen with no transfer at all.

// File: rtl/tx_cmd_seq.sv
module tx_cmd_seq #(
  parameter int AW          = 32,
  parameter int DW          = 32,
  parameter int LW          = 16,
  parameter int CW          = 8,
  parameter int CNT_LSB     = 16,
  parameter int C_BIT       = 15,
  parameter int DATA_OFS    = 12,
  parameter int DESC_STRIDE = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] cb_addr,
  output logic          busy,
  output logic          done,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  output logic          dma_start,
  output logic [AW-1:0] dma_addr,
  output logic [LW-1:0] dma_len,
  input  logic          dma_done,
  output logic          eoc_wr
);

  localparam logic [AW-1:0] NO_DESC = {AW{1'b1}};
  localparam logic [AW-1:0] WSTEP   = AW'(4);

  typedef enum logic [2:0] {ST_IDLE, ST_HDR, ST_RUN, ST_EOC, ST_WB} st_t;
  typedef enum logic [2:0] {MS_IDLE, MS_H0, MS_H1, MS_H2, MS_PA, MS_PC, MS_WB} ms_t;

  st_t           st;
  ms_t           ms;
  logic [AW-1:0] cb_q, ptr_q, pf_addr;
  logic [DW-1:0] hdr_q;
  logic [CW-1:0] cnt_q, pf_idx, launched;
  logic [LW-1:0] pf_len, size_w;
  logic          pf_valid, dma_busy;
  logic [AW-1:0] desc_base;

  assign desc_base = ptr_q + AW'(pf_idx) * AW'(DESC_STRIDE);
  assign size_w    = mem_rdata[LW-1:0];
  assign busy      = (st != ST_IDLE);
  assign mem_req   = (ms != MS_IDLE);
  assign mem_we    = (ms == MS_WB);
  assign mem_wdata = hdr_q | (DW'(1) << C_BIT);
  assign eoc_wr    = (st == ST_EOC);

  always_comb begin
    case (ms)
      MS_H0:   mem_addr = cb_q;
      MS_H1:   mem_addr = cb_q + WSTEP;
      MS_H2:   mem_addr = cb_q + WSTEP + WSTEP;
      MS_PA:   mem_addr = desc_base;
      MS_PC:   mem_addr = desc_base + WSTEP;
      MS_WB:   mem_addr = cb_q;
      default: mem_addr = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      ms        <= MS_IDLE;
      cb_q      <= '0;
      hdr_q     <= '0;
      ptr_q     <= '0;
      cnt_q     <= '0;
      pf_idx    <= '0;
      launched  <= '0;
      pf_valid  <= 1'b0;
      pf_addr   <= '0;
      pf_len    <= '0;
      dma_busy  <= 1'b0;
      dma_start <= 1'b0;
      dma_addr  <= '0;
      dma_len   <= '0;
      done      <= 1'b0;
    end else begin
      dma_start <= 1'b0;
      done      <= 1'b0;
      if (dma_done && dma_busy) dma_busy <= 1'b0;

      case (ms)
        MS_IDLE: if (st == ST_RUN && !pf_valid && pf_idx < cnt_q) ms <= MS_PA;
        MS_H0: if (mem_ack) begin
          hdr_q <= mem_rdata;
          ms    <= MS_H1;
        end
        MS_H1: if (mem_ack) begin
          ptr_q <= mem_rdata[AW-1:0];
          ms    <= MS_H2;
        end
        MS_H2: if (mem_ack) begin
          cnt_q <= (ptr_q == NO_DESC) ? '0 : mem_rdata[CNT_LSB +: CW];
          if (size_w != '0) begin
            dma_start <= 1'b1;
            dma_addr  <= cb_q + AW'(DATA_OFS);
            dma_len   <= size_w;
            dma_busy  <= 1'b1;
          end
          st <= ST_RUN;
          ms <= MS_IDLE;
        end
        MS_PA: if (mem_ack) begin
          pf_addr <= mem_rdata[AW-1:0];
          ms      <= MS_PC;
        end
        MS_PC: if (mem_ack) begin
          pf_len   <= mem_rdata[LW-1:0];
          pf_valid <= 1'b1;
          pf_idx   <= pf_idx + 1'b1;
          ms       <= MS_IDLE;
        end
        MS_WB: if (mem_ack) begin
          ms   <= MS_IDLE;
          st   <= ST_IDLE;
          done <= 1'b1;
        end
        default: ms <= MS_IDLE;
      endcase

      case (st)
        ST_IDLE: if (start) begin
          cb_q     <= cb_addr;
          cnt_q    <= '0;
          pf_idx   <= '0;
          launched <= '0;
          pf_valid <= 1'b0;
          ms       <= MS_H0;
          st       <= ST_HDR;
        end
        ST_RUN: begin
          if (!dma_busy && pf_valid) begin
            dma_start <= 1'b1;
            dma_addr  <= pf_addr;
            dma_len   <= pf_len;
            dma_busy  <= 1'b1;
            pf_valid  <= 1'b0;
            launched  <= launched + 1'b1;
          end else if (!dma_busy && !pf_valid && ms == MS_IDLE && launched == cnt_q) begin
            st <= ST_EOC;
          end
        end
        ST_EOC: begin
          st <= ST_WB;
          ms <= MS_WB;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/tx_cmd_seq_chk.sv
module tx_cmd_seq_chk #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int C_BIT = 15
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          done,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          mem_ack,
  input logic          dma_start,
  input logic          dma_done,
  input logic          eoc_wr,
  input logic [AW-1:0] cb_q
);

  logic out_q, eoc_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q    <= 1'b0;
      eoc_seen <= 1'b0;
    end else begin
      if (dma_start) out_q <= 1'b1;
      else if (dma_done) out_q <= 1'b0;
      if (eoc_wr) eoc_seen <= 1'b1;
      else if (done || start) eoc_seen <= 1'b0;
    end
  end

  a_r11_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  a_r8_wb_cbit: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_wdata[C_BIT] && mem_addr == cb_q);

  a_r8_wb_after_eoc: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> eoc_seen);

  a_r4_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    dma_start |-> !out_q);

  a_r7_eoc_after_dma: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_wr |-> !out_q && !dma_start);

  a_r7_eoc_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_wr |=> !eoc_wr);

endmodule

bind tx_cmd_seq tx_cmd_seq_chk #(.AW(AW), .DW(DW), .C_BIT(C_BIT)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .done(done),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .mem_ack(mem_ack), .dma_start(dma_start), .dma_done(dma_done), .eoc_wr(eoc_wr),
  .cb_q(cb_q)
);

// File: tb/tx_cmd_seq_tb_top.sv
`timescale 1ns/1ps
module tx_cmd_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] cb_addr = '0;
  logic        busy, done, mem_req, mem_we, dma_start, eoc_wr;
  logic [31:0] mem_addr, mem_wdata, dma_addr;
  logic [15:0] dma_len;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        dma_done = 1'b0;

  tx_cmd_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .cb_addr(cb_addr),
    .busy(busy), .done(done),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .dma_start(dma_start), .dma_addr(dma_addr), .dma_len(dma_len), .dma_done(dma_done),
    .eoc_wr(eoc_wr)
  );

  always #2.5 clk = ~clk;

  int n_checks = 0, n_fail = 0, cyc = 0;
  logic [31:0] mem [0:1023];
  int mem_lat_min = 0, mem_lat_max = 2, dma_lat_min = 0, dma_lat_max = 6;
  logic [31:0] ea[$];
  logic [15:0] el[$];
  string       et[$];
  int gaps[$];
  int desc_rd, wb_cnt, wb_cyc, eoc_cnt, eoc_cyc, eoc_bad, done_cnt, n_starts, last_done;
  bit dma_out = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  initial begin : mem_model
    int wc;
    bit pend;
    logic [31:0] a0;
    pend = 0; wc = 0; a0 = '0;
    forever begin
      @(negedge clk);
      if (mem_ack) mem_ack = 1'b0;
      else if (mem_req) begin
        if (!pend) begin
          pend = 1;
          a0 = mem_addr;
          wc = $urandom_range(mem_lat_max, mem_lat_min);
        end
        if (wc == 0) begin
          chk(a0 == mem_addr, "R11", "address held until ack", mem_addr, a0);
          if (mem_we) begin
            mem[mem_addr[11:2]] = mem_wdata;
            wb_cnt++;
            wb_cyc = cyc;
          end else begin
            mem_rdata = mem[mem_addr[11:2]];
            if (mem_addr >= 32'h800) desc_rd++;
          end
          pend = 0;
          mem_ack = 1'b1;
        end else wc--;
      end
    end
  end

  initial begin : dma_model
    int dc;
    logic [31:0] a;
    logic [15:0] l;
    string t;
    dc = 0;
    forever begin
      @(negedge clk);
      if (dma_done) dma_done = 1'b0;
      if (done) done_cnt++;
      if (eoc_wr) begin
        eoc_cnt++;
        eoc_cyc = cyc;
        if (dma_out || ea.size() != 0) eoc_bad++;
      end
      if (dma_start) begin
        if (ea.size() == 0) chk(0, "R4", "unexpected DMA", dma_addr, 32'hx);
        else begin
          a = ea.pop_front(); l = el.pop_front(); t = et.pop_front();
          chk(dma_addr == a, t, "DMA address", dma_addr, a);
          chk(dma_len == l, t, "DMA length", {16'h0, dma_len}, {16'h0, l});
        end
        if (n_starts > 0) gaps.push_back(cyc - last_done);
        n_starts++;
        dma_out = 1;
        dc = $urandom_range(dma_lat_max, dma_lat_min);
      end else if (dma_out) begin
        if (dc == 0) begin
          dma_done = 1'b1;
          dma_out = 0;
          last_done = cyc;
        end else dc--;
      end
    end
  end

  task automatic run_cmd(input logic [31:0] cb, input logic [31:0] hdr_in,
                         input logic [31:0] ptr, input int size, input int cnt);
    logic [31:0] hdr, w;
    int t;
    bit flex;
    hdr = hdr_in & ~32'h8000;
    flex = (ptr != 32'hFFFF_FFFF);
    mem[cb[11:2]]     = hdr;
    mem[cb[11:2] + 1] = ptr;
    mem[cb[11:2] + 2] = {8'h0, 8'(cnt), 16'(size)};
    ea.delete(); el.delete(); et.delete(); gaps.delete();
    if (size != 0) begin ea.push_back(cb + 12); el.push_back(16'(size)); et.push_back("R2"); end
    if (flex) for (int i = 0; i < cnt; i++) begin
      w = ptr + 8 * i;
      mem[w[11:2]]     = $urandom;
      mem[w[11:2] + 1] = $urandom;
      ea.push_back(mem[w[11:2]]);
      el.push_back(mem[w[11:2] + 1][15:0]);
      et.push_back(size == 0 && i == 0 ? "R3" : "R4");
    end
    desc_rd = 0; wb_cnt = 0; eoc_cnt = 0; eoc_bad = 0; done_cnt = 0; n_starts = 0;
    @(negedge clk); start = 1'b1; cb_addr = cb;
    @(negedge clk); start = 1'b0;
    chk(busy, "R12", "busy after start", {31'h0, busy}, 1);
    t = 0;
    while (done_cnt == 0 && t < 20000) begin @(negedge clk); t++; end
    repeat (2) @(negedge clk);
    chk(done_cnt == 1 && !busy, "R8", "done pulse then idle", done_cnt, 1);
    chk(ea.size() == 0, flex ? (cnt == 0 ? "R10" : "R4") : "R1", "DMAs left unissued", ea.size(), 0);
    chk(desc_rd == (flex ? 2 * cnt : 0), flex ? "R6" : "R1", "descriptor reads", desc_rd, flex ? 2 * cnt : 0);
    chk(eoc_cnt == 1 && eoc_bad == 0, "R7", "marker count / order", eoc_cnt, 1);
    chk(mem[cb[11:2]] == (hdr | 32'h8000) && wb_cnt == 1, "R8", "write-back word", mem[cb[11:2]], hdr | 32'h8000);
    chk(wb_cyc > eoc_cyc, "R8", "write-back after marker", wb_cyc, eoc_cyc);
  endtask

  initial begin : watchdog
    #1_000_000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin : main
    int mx;
    void'($urandom(32'd2024));
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    chk({busy, done, mem_req, dma_start, eoc_wr} == 5'b0, "R12", "reset outputs",
        {27'h0, busy, done, mem_req, dma_start, eoc_wr}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run_cmd(32'h040, 32'h1234_5678, 32'hFFFF_FFFF, 64, 3);   // R1 R2
    run_cmd(32'h080, 32'hA5A5_0001, 32'hFFFF_FFFF, 0, 2);    // R1 zero size
    run_cmd(32'h0C0, 32'h0000_00FF, 32'h0000_0840, 0, 3);    // R3
    run_cmd(32'h100, 32'hFFFF_7FFF, 32'h0000_0900, 0, 0);    // R10
    chk(n_starts == 0, "R10", "no DMA with zero count", n_starts, 0);

    mem_lat_min = 0; mem_lat_max = 0; dma_lat_min = 15; dma_lat_max = 15;
    run_cmd(32'h140, 32'h0BAD_0000, 32'h0000_0880, 100, 4);  // R5
    chk(gaps.size() == 4, "R5", "gap count", gaps.size(), 4);
    foreach (gaps[k]) chk(gaps[k] == 2, "R5", "back-to-back launch gap", gaps[k], 2);

    mem_lat_min = 8; mem_lat_max = 8; dma_lat_min = 0; dma_lat_max = 0;
    run_cmd(32'h180, 32'h0000_4000, 32'h0000_0A00, 20, 3);   // R9
    mx = 0;
    foreach (gaps[k]) if (gaps[k] > mx) mx = gaps[k];
    chk(mx > 2, "R9", "stall while descriptor pending", mx, 3);

    mem_lat_min = 0; mem_lat_max = 3; dma_lat_min = 0; dma_lat_max = 8;
    for (int n = 0; n < 30; n++) begin
      logic [31:0] p;
      p = ($urandom_range(3, 0) == 0) ? 32'hFFFF_FFFF : 32'h800 + 8 * $urandom_range(40, 0);
      run_cmd(32'(16 * $urandom_range(60, 0)), $urandom,
              p, ($urandom_range(2, 0) == 0) ? 0 : $urandom_range(1500, 1),
              $urandom_range(6, 0));
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule